// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address front end of a synchronous burst cache memory. Each clock it looks at two active-low address strobes, one driven by the processor and one by the cache controller, along with three chip selects, an advance input and a burst-order select. When a strobe starts an access, it captures the whole address. For the rest of a four-beat burst it then produces the array address on its own, stepping, holding or restarting as the inputs direct.

The two low address bits come from a 2-bit wrap-around beat counter. It walks them either in an XOR-interleaved order or in a linear order. The order select is latched when the access starts and holds for that burst. The outputs are the array address, a flag that marks an access as live, and a flag that records which strobe launched the access. A write-decode stage downstream needs that last flag.

Top module: `burst_addr_seq`

## Requirements
- R1: A new access starts at a rising edge only when `sel_a_n` is 0, `sel_b` is 1, `sel_c_n` is 0 and at least one strobe is 0. After that edge, `mem_addr` equals the captured `addr_i` and `burst_act` is 1.
- R2: When both strobes are 0 on a valid start, the processor strobe wins and `burst_from_proc` becomes 1. A start made by the controller strobe alone sets it to 0.
- R3: While `sel_a_n` is 1, the processor strobe has no effect. With the controller strobe at 1, the cycle acts as a continue or a suspend chosen by `adv_n`, and the captured address is not replaced.
- R4: With `order_ilv` = 1 latched at the start, the low two address bits at beat k are the start bits XOR k. A start of 01 gives 01, 00, 11, 10.
- R5: With `order_ilv` = 0 latched at the start, the low two bits at beat k are the start bits plus k, modulo 4. A start of 11 gives 11, 00, 01, 10.
- R6: With both strobes effectively 1 and `adv_n` = 0, the beat advances by one. This holds whatever the chip selects are.
- R7: With both strobes effectively 1 and `adv_n` = 1, `mem_addr` holds its value.
- R8: Address bits above bit 1 keep their captured value for the whole burst. A wrap of the beat counter never carries into them.
- R9: Every valid start resets the beat to zero, including a start made in the middle of a burst.
- R10: `order_ilv` is sampled only on a valid start. Changing it during a burst does not change that burst's order.
- R11: When a strobe is 0 but the chip selects are not all active, `burst_act` goes to 0 and the address and origin hold. `burst_act` stays 0 through continue and suspend cycles until the next valid start.
- R12: While `rst_n` is 0, `mem_addr` is 0, `burst_act` is 0 and `burst_from_proc` is 0. Reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Address captured on a valid start |
| proc_strb_n | input | 1 | Processor address strobe, active low, gated by sel_a_n |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Active-low advance: step the burst when no strobe is active |
| order_ilv | input | 1 | Burst order select: 1 interleaved, 0 linear |
| mem_addr | output | AW | Array address for the current beat |
| burst_act | output | 1 | Access is live |
| burst_from_proc | output | 1 | 1 when the current access was started by the processor strobe |

## Verification
The assertions assume that every control input is stable and known at each rising edge. They also assume that reset is released away from the edge, so that the first sampled cycle after release starts from the reset state. The stimulus meets both conditions. It changes every input on the falling edge only and releases reset there. It drives only 0 or 1, never an unknown, so the priority and gating checks always see a decided strobe pair.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Command decoded from the strobes, chip selects and advance input
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_ADV   = 2'd1,
    CMD_START = 2'd2,
    CMD_DESEL = 2'd3
  } bsq_cmd_e;

  localparam int unsigned BEAT_W = 2;

endpackage

// File: rtl/bsq_strobe_dec.sv
module bsq_strobe_dec
  import bsq_pkg::*;
(
  input  logic     proc_strb_n,
  input  logic     ctrl_strb_n,
  input  logic     sel_a_n,
  input  logic     sel_b,
  input  logic     sel_c_n,
  input  logic     adv_n,
  output bsq_cmd_e cmd_o,
  output logic     from_proc_o
);

  logic proc_eff;
  logic ctrl_eff;
  logic any_strb;
  logic chip_on;

  always_comb begin
    proc_eff    = !proc_strb_n && !sel_a_n;
    ctrl_eff    = !ctrl_strb_n;
    any_strb    = proc_eff || ctrl_eff;
    chip_on     = !sel_a_n && sel_b && !sel_c_n;
    from_proc_o = proc_eff;
    if (any_strb && chip_on)      cmd_o = CMD_START;
    else if (any_strb)            cmd_o = CMD_DESEL;
    else if (!adv_n)              cmd_o = CMD_ADV;
    else                          cmd_o = CMD_HOLD;
  end

endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bsq_cmd_e          cmd_i,
  input  logic [BEAT_W-1:0] start_low_i,
  input  logic              order_ilv_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              ilv_q, ilv_d;
  logic              load_en, step_en;

  always_comb begin
    load_en = (cmd_i == CMD_START);
    step_en = (cmd_i == CMD_ADV);
    base_d  = base_q;
    beat_d  = beat_q;
    ilv_d   = ilv_q;
    if (load_en) begin
      base_d = start_low_i;
      beat_d = '0;
      ilv_d  = order_ilv_i;
    end else if (step_en) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      ilv_q  <= ilv_d;
    end
  end

  always_comb begin
    if (ilv_q) low_o = base_q ^ beat_q;
    else       low_o = base_q + beat_q;
  end

  // R9: a start loads the presented low bits as beat zero
  a_r9_beat_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_START) |=> (low_o == $past(start_low_i)));

  // R5: linear order steps by one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ADV && !ilv_q) |=> (low_o == $past(low_o) + 1'b1));

  // R4: interleaved order flips bit 0 on every step
  a_r4_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ADV && ilv_q) |=> (low_o[0] != $past(low_o[0])));

  // R10: order select only changes on a start
  a_r10_order_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_START) |=> $stable(ilv_q));

endmodule

// File: rtl/bsq_addr_hold.sv
module bsq_addr_hold
  import bsq_pkg::*;
#(
  parameter int unsigned UW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bsq_cmd_e      cmd_i,
  input  logic [UW-1:0] upper_i,
  input  logic          from_proc_i,
  output logic [UW-1:0] upper_o,
  output logic          act_o,
  output logic          org_o
);

  logic [UW-1:0] upper_q, upper_d;
  logic          act_q, act_d;
  logic          org_q, org_d;

  always_comb begin
    upper_d = upper_q;
    act_d   = act_q;
    org_d   = org_q;
    unique case (cmd_i)
      CMD_START: begin
        upper_d = upper_i;
        act_d   = 1'b1;
        org_d   = from_proc_i;
      end
      CMD_DESEL: act_d = 1'b0;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      act_q   <= 1'b0;
      org_q   <= 1'b0;
    end else begin
      upper_q <= upper_d;
      act_q   <= act_d;
      org_q   <= org_d;
    end
  end

  assign upper_o = upper_q;
  assign act_o   = act_q;
  assign org_o   = org_q;

  // R8: upper bits change only on a start
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_START) |=> $stable(upper_o));

  // R11: deselect clears the live flag
  a_r11_desel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_DESEL) |=> !act_o);

  // R11: the flag cannot rise without a start
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && cmd_i != CMD_START) |=> !act_o);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_strb_n,
  input  logic          ctrl_strb_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          adv_n,
  input  logic          order_ilv,
  output logic [AW-1:0] mem_addr,
  output logic          burst_act,
  output logic          burst_from_proc
);

  localparam int unsigned UW = AW - BEAT_W;

  bsq_cmd_e          cmd;
  logic              from_proc;
  logic [BEAT_W-1:0] low;
  logic [UW-1:0]     upper;

  bsq_strobe_dec u_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .adv_n       (adv_n),
    .cmd_o       (cmd),
    .from_proc_o (from_proc)
  );

  bsq_beat_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .start_low_i (addr_i[BEAT_W-1:0]),
    .order_ilv_i (order_ilv),
    .low_o       (low)
  );

  bsq_addr_hold #(.UW(UW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .upper_i     (addr_i[AW-1:BEAT_W]),
    .from_proc_i (from_proc),
    .upper_o     (upper),
    .act_o       (burst_act),
    .org_o       (burst_from_proc)
  );

  assign mem_addr = {upper, low};

  // R1: a fully selected strobe starts an access at the captured address
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strb_n && !sel_a_n && sel_b && !sel_c_n) |=>
      (burst_act && mem_addr == $past(addr_i)));

  // R2: processor strobe wins when both are low
  a_r2_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && !ctrl_strb_n && !sel_a_n && sel_b && !sel_c_n) |=>
      burst_from_proc);

  // R3: a gated processor strobe alone does not change the upper address
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && ctrl_strb_n) |=> $stable(mem_addr[AW-1:BEAT_W]));

  // R7: suspend holds the address
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_strb_n || sel_a_n) && ctrl_strb_n && adv_n) |=> $stable(mem_addr));

  // R6: continue changes the low bits regardless of chip selects
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_strb_n || sel_a_n) && ctrl_strb_n && !adv_n) |=>
      (mem_addr[BEAT_W-1:0] != $past(mem_addr[BEAT_W-1:0])));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 18;
  localparam int NV = 20;

  typedef struct packed {
    logic          p_n;
    logic          c_n;
    logic          e1n;
    logic          e2;
    logic          e3n;
    logic          adv_n;
    logic          mode;
    logic [AW-1:0] addr;
    logic [AW-1:0] x_addr;
    logic          x_act;
    logic          x_org;
  } vec_t;

  // p_n c_n e1n e2 e3n adv_n mode addr x_addr x_act x_org
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h2A5C5,18'h2A5C5,1'b1,1'b1}, // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h2A5C4,1'b1,1'b1}, // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h2A5C7,1'b1,1'b1}, // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00000,18'h2A5C7,1'b1,1'b1}, // R7
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h2A5C6,1'b1,1'b1}, // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h2A5C5,1'b1,1'b1}, // R8
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h1FFFF,18'h1FFFF,1'b1,1'b0}, // R5
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,18'h1FFFC,1'b1,1'b0}, // R8
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,18'h3FFFF,18'h1FFFD,1'b1,1'b0}, // R3
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h1FFFE,1'b1,1'b0}, // R10
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,18'h00002,18'h00002,1'b1,1'b1}, // R2
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h00003,1'b1,1'b1}, // R4
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,18'h12345,18'h00003,1'b1,1'b1}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,18'h15555,18'h00003,1'b0,1'b1}, // R11
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,18'h00000,18'h00000,1'b0,1'b1}, // R6
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,18'h3FFFF,18'h00000,1'b0,1'b1}, // R11
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,18'h20000,18'h20000,1'b1,1'b0}, // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,18'h00000,18'h20001,1'b1,1'b0}, // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,18'h0FF01,18'h0FF01,1'b1,1'b0}, // R9
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,18'h00000,18'h0FF00,1'b1,1'b0}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_strb_n, ctrl_strb_n, sel_a_n, sel_b, sel_c_n, adv_n, order_ilv;
  logic [AW-1:0] mem_addr;
  logic          burst_act, burst_from_proc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_i          (addr_i),
    .proc_strb_n     (proc_strb_n),
    .ctrl_strb_n     (ctrl_strb_n),
    .sel_a_n         (sel_a_n),
    .sel_b           (sel_b),
    .sel_c_n         (sel_c_n),
    .adv_n           (adv_n),
    .order_ilv       (order_ilv),
    .mem_addr        (mem_addr),
    .burst_act       (burst_act),
    .burst_from_proc (burst_from_proc)
  );

  function automatic string req_of(int i);
    case (i)
      0, 16:         return "R1";
      10:            return "R2";
      8, 12:         return "R3";
      1, 2, 4, 11:   return "R4";
      6, 17:         return "R5";
      14:            return "R6";
      3:             return "R7";
      5, 7:          return "R8";
      18, 19:        return "R9";
      9:             return "R10";
      default:       return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [AW-1:0] xa, logic xact, logic xorg);
    n_chk++;
    if (mem_addr !== xa || burst_act !== xact || burst_from_proc !== xorg) begin
      n_fail++;
      $display("FAIL %s: addr/act/org = %h/%b/%b expected %h/%b/%b",
               req, mem_addr, burst_act, burst_from_proc, xa, xact, xorg);
    end
  endtask

  task automatic idle();
    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; sel_a_n = 1'b1;
    sel_b = 1'b0; sel_c_n = 1'b1; adv_n = 1'b1; order_ilv = 1'b0;
    addr_i = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R12", '0, 1'b0, 1'b0);          // R12 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      proc_strb_n = VEC[i].p_n;
      ctrl_strb_n = VEC[i].c_n;
      sel_a_n     = VEC[i].e1n;
      sel_b       = VEC[i].e2;
      sel_c_n     = VEC[i].e3n;
      adv_n       = VEC[i].adv_n;
      order_ilv   = VEC[i].mode;
      addr_i      = VEC[i].addr;
      @(posedge clk);
      @(negedge clk);
      check(req_of(i), VEC[i].x_addr, VEC[i].x_act, VEC[i].x_org);
    end
    // R12: asynchronous reset in the middle of a live burst
    #1 rst_n = 1'b0;
    #0.5 check("R12", '0, 1'b0, 1'b0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    // R11: after reset nothing is live until a start
    adv_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11", 18'h00001, 1'b0, 1'b0);
    // R2: controller-only start leaves origin at 0
    ctrl_strb_n = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    adv_n = 1'b1; addr_i = 18'h3C00A;
    @(posedge clk); @(negedge clk);
    check("R2", 18'h3C00A, 1'b1, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: done=%b expected 1", done);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule